// File: doc/BRIEF.md
# Lane Configuration Command Sequencer

This block carries out one configuration command against a transceiver lane controller over a memory-mapped register bus. A command has a 16-bit data value, a reset flag, a set/get flag, a 4-bit lane number, an 8-bit opcode and a channel index. The sequencer packs these fields into a 32-bit command word and writes it to the channel group's request register with the service-request flag set. It then polls the status register until the controller reports that the request is acknowledged and complete.

Next it writes the same word with the service-request flag cleared and polls again until the acknowledge drops. The status word from the final read is returned with a one-cycle done pulse. Each polling loop has a programmable limit. If a loop runs out, the command is marked as failed, but the deassert write is still issued.

The bus master is a plain request/acknowledge port with one access outstanding. A new command is taken only while the sequencer is idle.

Top module: `lane_cmd_seq`

## Requirements
- R1: Every command word is laid out as follows: data in [31:16], service-request in bit 15, reset flag in bit 14, set/get in bit 13 (1 = set, 0 = get), bit 12 always 0, lane in [11:8] and opcode in [7:0].
- R2: The first access after a command is accepted is a write of the command word with bit 15 = 1 to the request register.
- R3: After that write, the block reads the status register (request address + 4) repeatedly. It stops when a read returns bit 15 = 1 and bit 14 = 0. A read with bit 15 = 1 and bit 14 = 1 counts as busy, not complete.
- R4: After the first poll loop ends, the block writes the same command word with bit 15 = 0 to the request register.
- R5: After the deassert write, the block reads the status register repeatedly until a read returns bit 15 = 0.
- R6: The request register address is 0x0009003C + 0x00400000 × (channel / 4), which covers four groups of four channels.
- R7: A poll loop gives up after max(timeout_i, 1) reads that do not meet its exit condition. Running out in the first loop sets error_o and the deassert write and second loop still follow. Running out in the second loop sets error_o and ends the command.
- R8: done_o is high for exactly one cycle at the end of each command. status_o then holds the last status word read. error_o is valid with done_o and holds until the next command is accepted.
- R9: busy_o is high from the cycle after acceptance until the end of the command. cmd_ready_o is high only when the block is idle. cmd_valid_i has no effect while the block is busy.
- R10: Only one bus access is outstanding at a time. While bus_req_o is high and bus_ack_i is low, bus_we_o, bus_addr_o and bus_wdata_o stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block is idle and takes a command |
| cmd_data_i | input | 16 | Data value field |
| cmd_reset_i | input | 1 | Reset flag of the option field |
| cmd_set_i | input | 1 | 1 = set, 0 = get |
| cmd_lane_i | input | 4 | Lane number field |
| cmd_opcode_i | input | 8 | Opcode field |
| cmd_chan_i | input | 4 | Channel index |
| timeout_i | input | 16 | Polling read limit per loop |
| bus_req_o | output | 1 | Bus access request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Bus byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Access completed, read data valid |
| bus_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle end-of-command pulse |
| error_o | output | 1 | A poll loop ran out |
| status_o | output | 32 | Last status word read |

## Verification
The handshake is driven by a controller model that can be told how many busy or still-acknowledged reads to return before it answers. Tests with zero and several busy reads check that the number of polls follows the controller, not a fixed count. Busy responses with both bit 15 and bit 14 set check that completion needs the busy flag clear. Set and get commands on channels in different groups, with different field values, check the word packing and each group's address. Running out in the first loop and running out in the second loop give different traces: only the first must still issue the deassert write and a second poll loop. A zero limit checks the single-read floor.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANE_W = 4;
  localparam int unsigned OP_W   = 8;

  localparam int unsigned ST_ACK_BIT  = 15;
  localparam int unsigned ST_BUSY_BIT = 14;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              svc_req;
    logic              rst_flag;
    logic              set_get;
    logic              rsvd;
    logic [LANE_W-1:0] lane;
    logic [OP_W-1:0]   opcode;
  } cmd_word_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_SET,
    S_POLL_SET,
    S_WR_CLR,
    S_POLL_CLR
  } seq_state_e;
endpackage

// File: rtl/lcs_addr_map.sv
module lcs_addr_map #(
  parameter int unsigned          CHAN_W      = 4,
  parameter int unsigned          CH_PER_GRP  = 4,
  parameter logic [31:0]          BASE_ADDR   = 32'h0009_003C,
  parameter logic [31:0]          GRP_STRIDE  = 32'h0040_0000,
  parameter logic [31:0]          STS_OFFSET  = 32'h0000_0004
) (
  input  logic [CHAN_W-1:0] chan_i,
  output logic [31:0]       req_addr_o,
  output logic [31:0]       sts_addr_o
);
  localparam int unsigned GRP_SHIFT = $clog2(CH_PER_GRP);
  localparam int unsigned GRP_W     = (CHAN_W > GRP_SHIFT) ? CHAN_W - GRP_SHIFT : 1;

  logic [GRP_W-1:0] grp;

  generate
    if (CHAN_W > GRP_SHIFT) begin : g_grp
      assign grp = chan_i[CHAN_W-1:GRP_SHIFT];
    end else begin : g_single
      assign grp = '0;
    end
  endgenerate

  always_comb begin
    req_addr_o = BASE_ADDR + GRP_STRIDE * 32'(grp);
    sts_addr_o = req_addr_o + STS_OFFSET;
  end
endmodule

// File: rtl/lcs_word_pack.sv
module lcs_word_pack
  import lcs_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic              svc_req_i,
  input  logic              rst_flag_i,
  input  logic              set_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [OP_W-1:0]   opcode_i,
  output logic [WORD_W-1:0] word_o
);
  cmd_word_t w;

  always_comb begin
    w.data     = data_i;
    w.svc_req  = svc_req_i;
    w.rst_flag = rst_flag_i;
    w.set_get  = set_i;
    w.rsvd     = 1'b0;
    w.lane     = lane_i;
    w.opcode   = opcode_i;
    word_o     = w;
  end
endmodule

// File: rtl/lcs_poll_timer.sv
module lcs_poll_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             last_o
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W:0]   eff_limit;
  logic [TMO_W:0]   next_cnt;

  // zero limit still allows one read
  always_comb begin
    eff_limit = (limit_i == '0) ? (TMO_W+1)'(1) : {1'b0, limit_i};
    next_cnt  = {1'b0, cnt_q} + (TMO_W+1)'(1);
    last_o    = (next_cnt >= eff_limit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (inc_i)    cnt_q <= next_cnt[TMO_W-1:0];
  end

  AST_TMR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/lane_cmd_seq.sv
module lane_cmd_seq
  import lcs_pkg::*;
#(
  parameter int unsigned CHAN_W     = 4,
  parameter int unsigned CH_PER_GRP = 4,
  parameter int unsigned TMO_W      = 16,
  parameter logic [31:0] BASE_ADDR  = 32'h0009_003C,
  parameter logic [31:0] GRP_STRIDE = 32'h0040_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [15:0]       cmd_data_i,
  input  logic              cmd_reset_i,
  input  logic              cmd_set_i,
  input  logic [3:0]        cmd_lane_i,
  input  logic [7:0]        cmd_opcode_i,
  input  logic [CHAN_W-1:0] cmd_chan_i,
  input  logic [TMO_W-1:0]  timeout_i,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [31:0]       bus_addr_o,
  output logic [31:0]       bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [31:0]       bus_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic [31:0]       status_o
);
  seq_state_e state_q;

  logic [DATA_W-1:0] data_q;
  logic              rst_q, set_q;
  logic [LANE_W-1:0] lane_q;
  logic [OP_W-1:0]   op_q;
  logic [CHAN_W-1:0] chan_q;
  logic [31:0]       status_q;
  logic              error_q, done_q;

  logic [31:0] req_addr, sts_addr, word;
  logic        is_write, set_ok, clr_ok, tmr_clr, tmr_inc, tmr_last;

  lcs_addr_map #(
    .CHAN_W(CHAN_W), .CH_PER_GRP(CH_PER_GRP),
    .BASE_ADDR(BASE_ADDR), .GRP_STRIDE(GRP_STRIDE), .STS_OFFSET(32'h4)
  ) i_addr (
    .chan_i(chan_q), .req_addr_o(req_addr), .sts_addr_o(sts_addr)
  );

  lcs_word_pack i_pack (
    .data_i(data_q), .svc_req_i(state_q == S_WR_SET), .rst_flag_i(rst_q),
    .set_i(set_q), .lane_i(lane_q), .opcode_i(op_q), .word_o(word)
  );

  lcs_poll_timer #(.TMO_W(TMO_W)) i_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(tmr_clr), .inc_i(tmr_inc),
    .limit_i(timeout_i), .last_o(tmr_last)
  );

  always_comb begin
    is_write = (state_q == S_WR_SET) || (state_q == S_WR_CLR);
    set_ok   = bus_rdata_i[ST_ACK_BIT] && !bus_rdata_i[ST_BUSY_BIT];
    clr_ok   = !bus_rdata_i[ST_ACK_BIT];
    tmr_clr  = bus_ack_i && is_write;
    tmr_inc  = bus_ack_i && ((state_q == S_POLL_SET && !set_ok) ||
                             (state_q == S_POLL_CLR && !clr_ok));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      data_q   <= '0;
      rst_q    <= 1'b0;
      set_q    <= 1'b0;
      lane_q   <= '0;
      op_q     <= '0;
      chan_q   <= '0;
      status_q <= '0;
      error_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: if (cmd_valid_i) begin
          data_q  <= cmd_data_i;
          rst_q   <= cmd_reset_i;
          set_q   <= cmd_set_i;
          lane_q  <= cmd_lane_i;
          op_q    <= cmd_opcode_i;
          chan_q  <= cmd_chan_i;
          error_q <= 1'b0;
          state_q <= S_WR_SET;
        end
        S_WR_SET: if (bus_ack_i) state_q <= S_POLL_SET;
        S_POLL_SET: if (bus_ack_i) begin
          status_q <= bus_rdata_i;
          if (set_ok) state_q <= S_WR_CLR;
          else if (tmr_last) begin
            error_q <= 1'b1;
            state_q <= S_WR_CLR;
          end
        end
        S_WR_CLR: if (bus_ack_i) state_q <= S_POLL_CLR;
        S_POLL_CLR: if (bus_ack_i) begin
          status_q <= bus_rdata_i;
          if (clr_ok) begin
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end else if (tmr_last) begin
            error_q <= 1'b1;
            done_q  <= 1'b1;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == S_IDLE);
  assign busy_o      = (state_q != S_IDLE);
  assign bus_req_o   = (state_q != S_IDLE);
  assign bus_we_o    = is_write;
  assign bus_addr_o  = is_write ? req_addr : sts_addr;
  assign bus_wdata_o = is_write ? word : '0;
  assign done_o      = done_q;
  assign error_o     = error_q;
  assign status_o    = status_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_we_o) &&
      $stable(bus_addr_o) && $stable(bus_wdata_o))); // R10
  AST_POLL_AFTER_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o && bus_wdata_o[15] && bus_ack_i) |=>
      (bus_req_o && !bus_we_o)); // R3
  AST_CLR_AFTER_POLL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POLL_SET && bus_ack_i) |=>
      (state_q == S_POLL_SET || (bus_we_o && !bus_wdata_o[15]))); // R4
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o) |-> !bus_wdata_o[12]); // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && cmd_ready_o)); // R9
endmodule

// File: tb/test_lane_cmd_seq.sv
module test_lane_cmd_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_data = '0;
  logic        cmd_reset = 1'b0;
  logic        cmd_set = 1'b0;
  logic [3:0]  cmd_lane = '0;
  logic [7:0]  cmd_opcode = '0;
  logic [3:0]  cmd_chan = '0;
  logic [15:0] timeout = 16'd8;
  logic        bus_req, bus_we, bus_ack;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic        busy, done, error;
  logic [31:0] status;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  lane_cmd_seq i_lane_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_data_i(cmd_data), .cmd_reset_i(cmd_reset), .cmd_set_i(cmd_set),
    .cmd_lane_i(cmd_lane), .cmd_opcode_i(cmd_opcode), .cmd_chan_i(cmd_chan),
    .timeout_i(timeout),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_addr_o(bus_addr),
    .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .busy_o(busy), .done_o(done), .error_o(error), .status_o(status)
  );

  // controller model
  int          ack_dly = 0, clr_dly = 0;
  logic [15:0] tag = 16'h0;
  logic        req_on = 1'b0;
  int          cnt_set = 0, cnt_clr = 0;
  int          wr_total = 0, rd_set = 0, rd_clr = 0, bad_rd = 0;
  logic [31:0] wlog_addr [64];
  logic [31:0] wlog_data [64];
  logic [31:0] last_req_addr = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ack <= 1'b0;
      if (bus_req && !bus_ack) begin
        bus_ack <= 1'b1;
        if (bus_we) begin
          wlog_addr[wr_total % 64] <= bus_addr;
          wlog_data[wr_total % 64] <= bus_wdata;
          wr_total      <= wr_total + 1;
          last_req_addr <= bus_addr;
          req_on        <= bus_wdata[15];
          if (bus_wdata[15]) cnt_set <= ack_dly;
          else               cnt_clr <= clr_dly;
        end else begin
          if (bus_addr != last_req_addr + 32'd4) bad_rd <= bad_rd + 1;
          if (req_on) begin
            rd_set <= rd_set + 1;
            if (cnt_set > 0) begin
              bus_rdata <= cnt_set[0] ? 32'h0000_C000 : 32'h0000_0000;
              cnt_set   <= cnt_set - 1;
            end else bus_rdata <= {~tag, 16'h8000};
          end else begin
            rd_clr <= rd_clr + 1;
            if (cnt_clr > 0) begin
              bus_rdata <= 32'h0000_8000;
              cnt_clr   <= cnt_clr - 1;
            end else bus_rdata <= {tag, 16'h0000};
          end
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [3:0] ch);
    return 32'h0009_003C + 32'h0040_0000 * 32'(ch >> 2);
  endfunction

  function automatic logic [31:0] exp_word(input logic [15:0] d, input bit sreq,
      input bit r, input bit s, input logic [3:0] l, input logic [7:0] o);
    return {d, sreq, r, s, 1'b0, l, o};
  endfunction

  // runs one command; returns results sampled at the done pulse
  task automatic run_cmd(input logic [15:0] d, input bit r, input bit s,
      input logic [3:0] l, input logic [7:0] o, input logic [3:0] ch,
      input bit poke_busy, output int w0, output int r1, output int r2,
      output bit got_done);
    int guard;
    int rs0, rc0;
    @(negedge clk);
    w0 = wr_total; rs0 = rd_set; rc0 = rd_clr;
    cmd_data = d; cmd_reset = r; cmd_set = s; cmd_lane = l;
    cmd_opcode = o; cmd_chan = ch; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check(busy === 1'b1 && cmd_ready === 1'b0, "R9", "busy after accept",
          {30'd0, busy, cmd_ready}, 32'h2);
    if (poke_busy) begin
      cmd_chan = ch ^ 4'hC; cmd_data = ~d; cmd_valid = 1'b1;
      repeat (3) @(negedge clk);
      cmd_valid = 1'b0;
    end
    guard = 0;
    got_done = 1'b0;
    while (!done && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    got_done = done;
    r1 = rd_set - rs0;
    r2 = rd_clr - rc0;
  endtask

  task automatic t_reset;
    check(busy === 1'b0 && done === 1'b0 && error === 1'b0 && bus_req === 1'b0
          && cmd_ready === 1'b1, "R9", "reset state",
          {27'd0, busy, done, error, bus_req, cmd_ready}, 32'h1);
    check(status === 32'h0, "R8", "reset status", status, 32'h0);
  endtask

  task automatic t_basic(input logic [15:0] d, input bit r, input bit s,
      input logic [3:0] l, input logic [7:0] o, input logic [3:0] ch,
      input int ad, input int cd, input logic [15:0] tg, input bit poke);
    int w0, r1, r2;
    bit gd;
    ack_dly = ad; clr_dly = cd; tag = tg; timeout = 16'd8;
    run_cmd(d, r, s, l, o, ch, poke, w0, r1, r2, gd);
    check(gd, "R8", "done seen", {31'd0, gd}, 32'h1);
    check(wlog_addr[w0 % 64] === exp_addr(ch), "R6", "request address",
          wlog_addr[w0 % 64], exp_addr(ch));
    check(wlog_data[w0 % 64] === exp_word(d, 1, r, s, l, o), "R2", "set word",
          wlog_data[w0 % 64], exp_word(d, 1, r, s, l, o));
    check(wlog_data[(w0+1) % 64] === exp_word(d, 0, r, s, l, o), "R4",
          "clear word", wlog_data[(w0+1) % 64], exp_word(d, 0, r, s, l, o));
    check(wlog_addr[(w0+1) % 64] === exp_addr(ch), "R1", "clear address",
          wlog_addr[(w0+1) % 64], exp_addr(ch));
    check(wr_total - w0 == 2, "R9", "writes per command",
          32'(wr_total - w0), 32'd2);
    check(r1 == ad + 1, "R3", "set poll reads", 32'(r1), 32'(ad + 1));
    check(r2 == cd + 1, "R5", "clear poll reads", 32'(r2), 32'(cd + 1));
    check(status === {tg, 16'h0}, "R8", "final status", status, {tg, 16'h0});
    check(error === 1'b0, "R8", "no error", {31'd0, error}, 32'h0);
    check(bad_rd == 0, "R3", "status read address", 32'(bad_rd), 32'h0);
    @(negedge clk);
    check(done === 1'b0, "R8", "done one cycle", {31'd0, done}, 32'h0);
  endtask

  task automatic t_tmo_set;
    int w0, r1, r2;
    bit gd;
    ack_dly = 1000; clr_dly = 0; tag = 16'h7E11; timeout = 16'd6;
    run_cmd(16'h0020, 0, 1, 4'h3, 8'h0F, 4'd9, 0, w0, r1, r2, gd);
    check(gd && error === 1'b1, "R7", "set loop timeout error",
          {30'd0, gd, error}, 32'h3);
    check(r1 == 6, "R7", "reads before give-up", 32'(r1), 32'd6);
    check(wlog_data[(w0+1) % 64] === exp_word(16'h0020, 0, 0, 1, 4'h3, 8'h0F),
          "R7", "deassert after timeout", wlog_data[(w0+1) % 64],
          exp_word(16'h0020, 0, 0, 1, 4'h3, 8'h0F));
    check(r2 == 1 && status === {16'h7E11, 16'h0}, "R7", "clear loop after timeout",
          status, {16'h7E11, 16'h0});
    @(negedge clk);
    check(error === 1'b1, "R8", "error held", {31'd0, error}, 32'h1);
  endtask

  task automatic t_tmo_clr;
    int w0, r1, r2;
    bit gd;
    ack_dly = 0; clr_dly = 1000; tag = 16'h0BAD; timeout = 16'd0;
    run_cmd(16'h0249, 1, 0, 4'h1, 8'h66, 4'd2, 0, w0, r1, r2, gd);
    check(gd && error === 1'b1, "R7", "clear loop timeout error",
          {30'd0, gd, error}, 32'h3);
    check(r1 == 1 && r2 == 1, "R7", "zero limit single read",
          32'(r1 * 16 + r2), 32'h11);
    check(status === 32'h0000_8000, "R8", "status at clear timeout",
          status, 32'h0000_8000);
    check(wr_total - w0 == 2, "R7", "no extra writes", 32'(wr_total - w0), 32'd2);
  endtask

  task automatic t_err_clear;
    t_basic(16'h0000, 0, 0, 4'h0, 8'h49, 4'd0, 0, 0, 16'h1234, 0);
  endtask

  initial begin
    #1_000_000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_basic(16'h0006, 0, 1, 4'h2, 8'h40, 4'd5, 0, 0, 16'hA001, 0);
    t_basic(16'h0A69, 1, 0, 4'hF, 8'h45, 4'd14, 3, 2, 16'hA002, 0);
    t_basic(16'hFFFF, 0, 1, 4'h5, 8'hB1, 4'd11, 5, 4, 16'hA003, 0);
    t_basic(16'h0861, 1, 1, 4'hA, 8'h0D, 4'd3, 4, 1, 16'hA004, 1);
    t_tmo_set();
    t_err_clear();
    t_tmo_clr();
    t_basic(16'h0021, 0, 0, 4'h7, 8'h41, 4'd12, 2, 0, 16'hA005, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule